// File: doc/BRIEF.md
# Shadowed Raster Timing Generator

This block drives the timing side of a raster display. It runs a pixel counter and a line counter, and from them it produces horizontal sync, vertical sync, a data-enable strobe and two independent kick pulses at programmed positions. Software sets the geometry through a small 32-bit register port. Lengths are written as value minus one, and the sync position is given by its distance to the end of the line. A timestamp word reports a running frame count together with the current line.

Timing words can be written straight into the live set. They can also be written into a staging copy that stays inactive until software posts a load token. The token is taken at the next frame boundary. All staged words then move into the live set on the same clock, so that no frame runs on a mix of old and new timing. One run bit starts and stops the generator.

Register map (word address): 0 control (bit 0 = staging enable), 1 horizontal size, 2 horizontal sync, 3 vertical size, 4 vertical sync, 5 primary kick, 6 secondary kick, 7 run (bit 0), 8 load token (write bit 0 = post, read bit 0 = pending), 9 timestamp (read only).

Top module: `vtg_frame_gen`

## Requirements
- R1: While running, the pixel counter `pix_x` counts from 0 up to the horizontal total field (bits 29:16 of word 1, total minus one) and then wraps to 0. On that wrap, `line_y` advances, and it returns to 0 after reaching the vertical total field (bits 29:16 of word 3).
- R2: `de` is high when the pixel count is below the active width (bits 13:0 of word 1) and the line count is below the active height (bits 13:0 of word 3).
- R3: With bit 31 of word 2 set, `hsync` is high for pixel counts from S = total field minus sync-plus-back-porch field (bits 29:16) up to S plus the sync width field (bits 13:0), both ends included.
- R4: `vsync` follows the same rule as R3, applied to line counts and word 4.
- R5: A kick word carries enable in bit 31, row in bits 29:16 and column in bits 13:0. Its output pulses for exactly one clock when the counters match column and row with the enable set. It never pulses while the enable is clear.
- R6: Word 9 reads as the frame index in bits 31:14 and the line count in bits 13:0. The frame index increments once each time both counters wrap together.
- R7: With the staging enable set, writes to words 1 to 6 do not change the running timing.
- R8: A posted token is consumed at the first frame wrap that follows it. All six staged words become live for the new frame, and the pending flag clears.
- R9: With run clear, the counters sit at 0, every output is low and the frame index keeps its value.
- R10: After synchronous reset, all outputs, counters, registers and read data are 0.
- R11: With the sync enable bit of word 2 or word 4 clear, that sync output stays low.
- R12: Reads return the last value written to words 0 to 7 (the staged value for timing words) one clock after the address is presented.
- R13: The outputs `hsync`, `vsync`, `de` and the kicks are registered. Each reflects the counter position one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Active-region strobe |
| kick_pri | output | 1 | Primary kick pulse |
| kick_sec | output | 1 | Secondary kick pulse |
| pix_x | output | 14 | Pixel counter |
| line_y | output | 14 | Line counter |

## Verification
The bench tracks a cycle-exact arithmetic model through a small 10-by-6 raster and compares every output and the read data on every clock. These comparisons cover the edges of the sync windows, the last pixel of the last line, and the kicks.

The riskiest case is a staged rewrite of the horizontal total in the middle of a frame. A design that applied staged words early would wrap the pixel counter at the wrong point. A design that committed on a line wrap instead of a frame wrap, or never cleared the token, would lose step with the model at once.

Clearing the sync enable bit and the secondary kick enable checks that those outputs really go silent. Stopping and restarting checks that the frame index freezes and is not reset. An off-by-one in the minus-one decoding would shift the sync by one pixel and show up at the window edges.

// File: rtl/vtg_pkg.sv
package vtg_pkg;
  localparam int CNT_W    = 14;  // counter and field width
  localparam int HI_LSB   = 16;  // lsb of upper field
  localparam int EN_BIT   = 31;  // enable bit of sync and kick words
  localparam int ADDR_W   = 4;
  localparam int NUM_TREG = 6;   // staged timing words
  localparam int FRM_W    = 32 - CNT_W;

  localparam int A_CTRL   = 0;
  localparam int A_TBASE  = 1;   // first timing word
  localparam int A_RUN    = 7;
  localparam int A_TOKEN  = 8;
  localparam int A_TSTAMP = 9;

  typedef struct packed {
    logic [CNT_W-1:0] tot;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] sw;
    logic [CNT_W-1:0] sbp;
    logic             sen;
  } axis_t;

  typedef struct packed {
    logic             en;
    logic [CNT_W-1:0] row;
    logic [CNT_W-1:0] col;
  } kick_t;

  typedef struct packed {
    axis_t h;
    axis_t v;
    kick_t kp;
    kick_t ks;
  } cfg_t;
endpackage

// File: rtl/vtg_regs.sv
module vtg_regs
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              frame_end,
  input  logic [31:0]       tstamp,
  output logic              run,
  output logic              pending,
  output cfg_t              cfg,
  output logic [31:0]       rdata
);
  logic [NUM_TREG-1:0][31:0] shd_q;
  logic [NUM_TREG-1:0][31:0] act_q;
  logic                      shd_en_q;
  logic                      commit;
  logic                      unused_bits;

  assign commit = frame_end & pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q    <= '0;
      act_q    <= '0;
      shd_en_q <= 1'b0;
      run      <= 1'b0;
      pending  <= 1'b0;
    end else begin
      if (commit) act_q <= shd_q;
      for (int i = 0; i < NUM_TREG; i++) begin
        if (wr && addr == ADDR_W'(A_TBASE + i)) begin
          shd_q[i] <= wdata;
          if (!shd_en_q) act_q[i] <= wdata;
        end
      end
      if (wr && addr == ADDR_W'(A_CTRL)) shd_en_q <= wdata[0];
      if (wr && addr == ADDR_W'(A_RUN))  run      <= wdata[0];
      pending <= (pending & ~commit) | (wr && addr == ADDR_W'(A_TOKEN) && wdata[0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else begin
      rdata <= '0;
      if (addr == ADDR_W'(A_CTRL))        rdata <= {31'd0, shd_en_q};
      else if (addr == ADDR_W'(A_RUN))    rdata <= {31'd0, run};
      else if (addr == ADDR_W'(A_TOKEN))  rdata <= {31'd0, pending};
      else if (addr == ADDR_W'(A_TSTAMP)) rdata <= tstamp;
      else
        for (int i = 0; i < NUM_TREG; i++)
          if (addr == ADDR_W'(A_TBASE + i)) rdata <= shd_q[i];
    end
  end

  assign cfg.h.tot = act_q[0][HI_LSB +: CNT_W];
  assign cfg.h.act = act_q[0][0 +: CNT_W];
  assign cfg.h.sbp = act_q[1][HI_LSB +: CNT_W];
  assign cfg.h.sw  = act_q[1][0 +: CNT_W];
  assign cfg.h.sen = act_q[1][EN_BIT];
  assign cfg.v.tot = act_q[2][HI_LSB +: CNT_W];
  assign cfg.v.act = act_q[2][0 +: CNT_W];
  assign cfg.v.sbp = act_q[3][HI_LSB +: CNT_W];
  assign cfg.v.sw  = act_q[3][0 +: CNT_W];
  assign cfg.v.sen = act_q[3][EN_BIT];
  assign cfg.kp.en  = act_q[4][EN_BIT];
  assign cfg.kp.row = act_q[4][HI_LSB +: CNT_W];
  assign cfg.kp.col = act_q[4][0 +: CNT_W];
  assign cfg.ks.en  = act_q[5][EN_BIT];
  assign cfg.ks.row = act_q[5][HI_LSB +: CNT_W];
  assign cfg.ks.col = act_q[5][0 +: CNT_W];

  assign unused_bits = ^act_q;
endmodule

// File: rtl/vtg_counters.sv
module vtg_counters
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] h_tot,
  input  logic [CNT_W-1:0] v_tot,
  output logic [CNT_W-1:0] hcnt,
  output logic [CNT_W-1:0] vcnt,
  output logic [FRM_W-1:0] frame_idx,
  output logic             frame_end
);
  logic hwrap, vwrap;

  assign hwrap     = hcnt >= h_tot;
  assign vwrap     = vcnt >= v_tot;
  assign frame_end = run & hwrap & vwrap;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= hwrap ? '0 : hcnt + 1'b1;
      if (hwrap) vcnt <= vwrap ? '0 : vcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            frame_idx <= '0;
    else if (frame_end) frame_idx <= frame_idx + 1'b1;
  end
endmodule

// File: rtl/vtg_decode.sv
module vtg_decode
  import vtg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [CNT_W-1:0] hcnt,
  input  logic [CNT_W-1:0] vcnt,
  input  cfg_t             cfg,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             kick_pri,
  output logic             kick_sec
);
  logic [CNT_W-1:0] h_start, v_start;
  logic hs_d, vs_d, de_d, kp_d, ks_d;

  assign h_start = cfg.h.tot - cfg.h.sbp;
  assign v_start = cfg.v.tot - cfg.v.sbp;

  always_comb begin
    hs_d = cfg.h.sen && hcnt >= h_start && (hcnt - h_start) <= cfg.h.sw;
    vs_d = cfg.v.sen && vcnt >= v_start && (vcnt - v_start) <= cfg.v.sw;
    de_d = hcnt < cfg.h.act && vcnt < cfg.v.act;
    kp_d = cfg.kp.en && hcnt == cfg.kp.col && vcnt == cfg.kp.row;
    ks_d = cfg.ks.en && hcnt == cfg.ks.col && vcnt == cfg.ks.row;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hsync <= 1'b0; vsync <= 1'b0; de <= 1'b0;
      kick_pri <= 1'b0; kick_sec <= 1'b0;
    end else begin
      hsync <= hs_d; vsync <= vs_d; de <= de_d;
      kick_pri <= kp_d; kick_sec <= ks_d;
    end
  end
endmodule

// File: rtl/vtg_frame_gen.sv
module vtg_frame_gen
  import vtg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic              kick_pri,
  output logic              kick_sec,
  output logic [CNT_W-1:0]  pix_x,
  output logic [CNT_W-1:0]  line_y
);
  cfg_t             cfg;
  logic             run, pending, frame_end;
  logic [FRM_W-1:0] frame_idx;

  vtg_regs u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .frame_end(frame_end), .tstamp({frame_idx, line_y}),
    .run(run), .pending(pending), .cfg(cfg), .rdata(bus_rdata)
  );

  vtg_counters u_cnt (
    .clk(clk), .rst(rst), .run(run), .h_tot(cfg.h.tot), .v_tot(cfg.v.tot),
    .hcnt(pix_x), .vcnt(line_y), .frame_idx(frame_idx), .frame_end(frame_end)
  );

  vtg_decode u_dec (
    .clk(clk), .rst(rst), .run(run), .hcnt(pix_x), .vcnt(line_y), .cfg(cfg),
    .hsync(hsync), .vsync(vsync), .de(de), .kick_pri(kick_pri), .kick_sec(kick_sec)
  );
endmodule

// File: rtl/vtg_frame_gen_chk.sv
module vtg_frame_gen_chk
  import vtg_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             pending,
  input logic             frame_end,
  input logic             de,
  input logic [CNT_W-1:0] pix_x,
  input logic [CNT_W-1:0] line_y,
  input logic [CNT_W-1:0] h_tot,
  input logic [FRM_W-1:0] frame_idx
);
  // R9
  halt_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pix_x == '0 && line_y == '0));
  // R1
  pix_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && pix_x < h_tot) |=> (pix_x == $past(pix_x) + 1'b1));
  // R6
  frame_step_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_idx != $past(frame_idx)) |-> (frame_idx == $past(frame_idx) + 1'b1));
  // R8
  token_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pending) |-> $past(frame_end));
  // R2
  de_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    de |-> $past(run));
endmodule

bind vtg_frame_gen vtg_frame_gen_chk u_chk (
  .clk(clk), .rst(rst), .run(run), .pending(pending), .frame_end(frame_end),
  .de(de), .pix_x(pix_x), .line_y(line_y), .h_tot(cfg.h.tot), .frame_idx(frame_idx)
);

// File: tb/vtg_frame_gen_bench.sv
module vtg_frame_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        hsync, vsync, de, kick_pri, kick_sec;
  logic [13:0] pix_x, line_y;

  int errors = 0;
  int checks = 0;

  // model state
  logic [31:0] m_shd [6];
  logic [31:0] m_act [6];
  int m_h, m_v, m_fr;
  bit m_run, m_shden, m_pend;

  always #4 clk = ~clk;

  vtg_frame_gen u_vtg_frame_gen (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hsync(hsync), .vsync(vsync),
    .de(de), .kick_pri(kick_pri), .kick_sec(kick_sec), .pix_x(pix_x), .line_y(line_y)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int hi(input logic [31:0] w); return int'(w[29:16]); endfunction
  function automatic int lo(input logic [31:0] w); return int'(w[13:0]);  endfunction

  function automatic bit in_sync(input int c, input logic [31:0] wa, input logic [31:0] wb);
    int st;
    st = (hi(wa) - hi(wb)) & 16'h3fff;
    return wb[31] && c >= st && (c - st) <= lo(wb);
  endfunction

  function automatic logic [31:0] m_read(input int a);
    case (a)
      0: return {31'd0, m_shden};
      1, 2, 3, 4, 5, 6: return m_shd[a-1];
      7: return {31'd0, m_run};
      8: return {31'd0, m_pend};
      9: return {m_fr[17:0], m_v[13:0]};
      default: return 32'd0;
    endcase
  endfunction

  // one clock: predict, advance model, compare at the falling edge
  task automatic step();
    bit e_hs, e_vs, e_de, e_kp, e_ks, fe;
    logic [31:0] e_rd;
    int a;
    a    = int'(bus_addr);
    e_rd = m_read(a);
    e_hs = m_run && in_sync(m_h, m_act[0], m_act[1]);
    e_vs = m_run && in_sync(m_v, m_act[2], m_act[3]);
    e_de = m_run && m_h < lo(m_act[0]) && m_v < lo(m_act[2]);
    e_kp = m_run && m_act[4][31] && m_h == lo(m_act[4]) && m_v == hi(m_act[4]);
    e_ks = m_run && m_act[5][31] && m_h == lo(m_act[5]) && m_v == hi(m_act[5]);
    fe = m_run && m_h >= hi(m_act[0]) && m_v >= hi(m_act[2]);
    if (!m_run) begin m_h = 0; m_v = 0; end
    else if (m_h >= hi(m_act[0])) begin
      m_h = 0;
      m_v = (m_v >= hi(m_act[2])) ? 0 : m_v + 1;
    end else m_h = m_h + 1;
    if (fe) m_fr = m_fr + 1;
    if (fe && m_pend) begin
      for (int i = 0; i < 6; i++) m_act[i] = m_shd[i];
      m_pend = 0;
    end
    if (bus_wr) begin
      if (a >= 1 && a <= 6) begin
        m_shd[a-1] = bus_wdata;
        if (!m_shden) m_act[a-1] = bus_wdata;
      end
      if (a == 0) m_shden = bus_wdata[0];
      if (a == 7) m_run = bus_wdata[0];
      if (a == 8 && bus_wdata[0]) m_pend = 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk("R3/R11/R13 hsync", {31'd0, hsync}, {31'd0, e_hs});
    chk("R4/R11/R13 vsync", {31'd0, vsync}, {31'd0, e_vs});
    chk("R2 de", {31'd0, de}, {31'd0, e_de});
    chk("R5 kick_pri", {31'd0, kick_pri}, {31'd0, e_kp});
    chk("R5 kick_sec", {31'd0, kick_sec}, {31'd0, e_ks});
    chk("R1/R7/R8/R9 pix_x", {18'd0, pix_x}, m_h);
    chk("R1/R7/R8/R9 line_y", {18'd0, line_y}, m_v);
    chk("R6/R12 rdata", bus_rdata, e_rd);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_addr  = 4'(a);
    bus_wdata = d;
    bus_wr    = 1'b1;
    step();
    bus_wr    = 1'b0;
  endtask

  task automatic run_for(input int a, input int n);
    bus_addr = 4'(a);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_shd[i] = '0; m_act[i] = '0; end
    m_h = 0; m_v = 0; m_fr = 0; m_run = 0; m_shden = 0; m_pend = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 hsync", {31'd0, hsync}, 0);
    chk("R10 vsync", {31'd0, vsync}, 0);
    chk("R10 de", {31'd0, de}, 0);
    chk("R10 kicks", {30'd0, kick_pri, kick_sec}, 0);
    chk("R10 counters", {4'd0, pix_x, line_y}, 0);
    chk("R10 rdata", bus_rdata, 0);
    run_for(9, 3);
    // direct programming: 10x6 raster, active 6x4
    wr(1, (32'd9 << 16) | 32'd6);
    wr(2, 32'h8000_0000 | (32'd3 << 16) | 32'd1);
    wr(3, (32'd5 << 16) | 32'd4);
    wr(4, 32'h8000_0000 | (32'd1 << 16) | 32'd0);
    wr(5, 32'h8000_0000 | (32'd2 << 16) | 32'd3);
    wr(6, 32'h8000_0000 | (32'd5 << 16) | 32'd7);
    for (int a = 0; a < 8; a++) run_for(a, 1);   // R12 readback
    wr(7, 32'd1);
    run_for(9, 187);                             // R1..R6 sweep
    // R7: staged rewrite mid-frame must not take effect
    wr(0, 32'd1);
    wr(1, (32'd7 << 16) | 32'd5);
    wr(2, 32'h8000_0000 | (32'd3 << 16) | 32'd2);
    run_for(1, 2);                               // R12 staged readback
    run_for(9, 20);
    // R8: token, pending flag, commit at frame wrap
    wr(8, 32'd1);
    run_for(8, 10);
    run_for(9, 140);
    run_for(8, 2);
    // R11 and R5: sync enable and secondary kick enable cleared
    wr(0, 32'd0);
    wr(2, (32'd3 << 16) | 32'd2);
    wr(4, (32'd1 << 16) | 32'd0);
    wr(6, (32'd5 << 16) | 32'd7);
    run_for(9, 110);
    // R9: stop, counters zero, frame index frozen
    wr(7, 32'd0);
    run_for(9, 40);
    wr(7, 32'd1);
    run_for(9, 60);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule